// File: doc/BRIEF.md
# TLB Replacement Pointer Unit

This block holds the replacement state of a small address-translation cache pair: a 4-slot instruction TLB and a 64-slot unified TLB. For the instruction side it keeps a 6-bit pairwise age field, one bit per pair of slots. A fixed pattern match on that field picks the slot to overwrite on a refill. For the unified side it keeps a 6-bit rotating counter. Each unified-TLB access advances the counter, and a software-set limit bounds how far it runs.

Lookup logic drives the strobes. It signals which instruction slot hit, when an instruction miss was refilled from the unified TLB, and when the unified TLB was accessed. Software loads all three fields (age field, counter and limit) with one write. The outputs are the slot to replace, the current counter value and a flag that marks an age pattern no legal access history can produce.

Top module: `tlb_repl_ptr`

## Requirements
- R1: After reset the age field, the counter and the limit are all zero, so the victim is 3, the counter reads 0 and the error flag is low.
- R2: The age field age[5:0] is decoded in priority order 0, 1, 2, 3. Slot 0 is the victim when age[5:3]=111. Slot 1 is the victim when age[5]=0 and age[2:1]=11. Slot 2 is the victim when age[4]=0, age[2]=0 and age[0]=1. Slot 3 is the victim when age[3]=0, age[1]=0 and age[0]=0.
- R3: An age pattern that matches no slot drives the error flag high and the victim to 0 (for example 6'b011011).
- R4: A hit strobe on slot k updates the age field. Slot 0 clears age[5:3]. Slot 1 sets age[5] and clears age[2:1]. Slot 2 sets age[4] and age[2] and clears age[0]. Slot 3 sets age[3], age[1] and age[0]. From reset, this makes the victim the least recently used slot.
- R5: A refill strobe marks the current victim as most recently used, with the R4 update. In the same cycle it takes precedence over a hit strobe.
- R6: Each unified-access strobe increments the counter by one in the next cycle. Without a strobe the counter holds.
- R7: With a nonzero limit, an increment that would exceed the limit gives 0 instead. This also applies when the counter already exceeds the limit.
- R8: With a zero limit, the counter runs through 63 and then returns to 0.
- R9: A register write loads the age field, the limit and the counter from their write ports in the next cycle. It overrides every strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_age_i | input | 6 | Age field write value |
| reg_lim_i | input | 6 | Counter limit write value |
| reg_cnt_i | input | 6 | Counter write value |
| itlb_hit_i | input | 1 | Instruction TLB hit strobe |
| itlb_hit_idx_i | input | 2 | Slot that hit |
| itlb_refill_i | input | 1 | Refill into the current victim slot |
| utlb_acc_i | input | 1 | Unified TLB access strobe |
| itlb_victim_o | output | 2 | Slot to replace next |
| utlb_cnt_o | output | 6 | Current counter value |
| age_err_o | output | 1 | Age field matches no slot |

## Verification
The assertions check several rules on every cycle. The error flag always forces victim 0. The counter is stable without a strobe and steps by one below the maximum when the limit is zero. It clears once it reaches a nonzero limit, and it loads on a write. A hit or refill always moves the touched slot off the victim output unless the field has gone illegal. Only the bench scenarios can show the exact slot ordering against a recency model, the refill-over-hit precedence, the decode of each written pattern, the illegal pattern, and the full 64-step wrap.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;
  localparam int unsigned ITLB_N     = 4;
  localparam int unsigned ITLB_IDX_W = $clog2(ITLB_N);
  localparam int unsigned AGE_W      = ITLB_N * (ITLB_N - 1) / 2;

  typedef logic [AGE_W-1:0] age_t;

  // bits examined when testing slot e as victim
  function automatic age_t victim_care(input int unsigned e);
    case (e)
      0:       return 6'b111000;
      1:       return 6'b100110;
      2:       return 6'b010101;
      default: return 6'b001011;
    endcase
  endfunction

  // value those bits must hold for slot e to be victim
  function automatic age_t victim_val(input int unsigned e);
    case (e)
      0:       return 6'b111000;
      1:       return 6'b000110;
      2:       return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction
endpackage

// File: rtl/tlb_itlb_age.sv
module tlb_itlb_age
  import tlb_repl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  age_t                  load_val_i,
  input  logic                  touch_i,
  input  logic [ITLB_IDX_W-1:0] touch_idx_i,
  output logic [ITLB_IDX_W-1:0] victim_o,
  output logic                  err_o
);
  age_t              age_q, age_d;
  logic [ITLB_N-1:0] match;

  for (genvar e = 0; e < ITLB_N; e++) begin : g_match
    assign match[e] = (age_q & victim_care(e)) == victim_val(e);
  end

  always_comb begin
    victim_o = '0;
    for (int e = ITLB_N - 1; e >= 0; e--) begin
      if (match[e]) victim_o = ITLB_IDX_W'(e);
    end
    err_o = ~|match;
  end

  // a touched slot takes the inverse of its own victim pattern
  always_comb begin
    age_t care, val;
    care  = victim_care(int'(touch_idx_i));
    val   = victim_val(int'(touch_idx_i));
    age_d = age_q;
    if (load_i)       age_d = load_val_i;
    else if (touch_i) age_d = (age_q & ~care) | (care & ~val);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else         age_q <= age_d;
  end
endmodule

// File: rtl/tlb_utlb_ctr.sv
module tlb_utlb_ctr #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic [CNT_W-1:0] load_lim_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic [CNT_W:0]   inc;
  logic             wrap;

  assign inc   = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign wrap  = ((lim_q != '0) && (inc > {1'b0, lim_q})) || inc[CNT_W];
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_cnt_i;
      lim_q <= load_lim_i;
    end else if (step_i) begin
      cnt_q <= wrap ? '0 : inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr
  import tlb_repl_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [AGE_W-1:0]      reg_age_i,
  input  logic [CNT_W-1:0]      reg_lim_i,
  input  logic [CNT_W-1:0]      reg_cnt_i,
  input  logic                  itlb_hit_i,
  input  logic [ITLB_IDX_W-1:0] itlb_hit_idx_i,
  input  logic                  itlb_refill_i,
  input  logic                  utlb_acc_i,
  output logic [ITLB_IDX_W-1:0] itlb_victim_o,
  output logic [CNT_W-1:0]      utlb_cnt_o,
  output logic                  age_err_o
);
  logic                  touch;
  logic [ITLB_IDX_W-1:0] touch_idx;

  // refill claims the victim slot ahead of a hit report
  assign touch     = itlb_refill_i | itlb_hit_i;
  assign touch_idx = itlb_refill_i ? itlb_victim_o : itlb_hit_idx_i;

  tlb_itlb_age u_age (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (reg_we_i),
    .load_val_i  (reg_age_i),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .victim_o    (itlb_victim_o),
    .err_o       (age_err_o)
  );

  tlb_utlb_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (reg_we_i),
    .load_cnt_i (reg_cnt_i),
    .load_lim_i (reg_lim_i),
    .step_i     (utlb_acc_i),
    .cnt_o      (utlb_cnt_o)
  );
endmodule

// File: rtl/tlb_repl_ptr_chk.sv
module tlb_repl_ptr_chk
  import tlb_repl_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [CNT_W-1:0]      reg_lim_i,
  input logic [CNT_W-1:0]      reg_cnt_i,
  input logic                  itlb_hit_i,
  input logic [ITLB_IDX_W-1:0] itlb_hit_idx_i,
  input logic                  itlb_refill_i,
  input logic                  utlb_acc_i,
  input logic [ITLB_IDX_W-1:0] itlb_victim_o,
  input logic [CNT_W-1:0]      utlb_cnt_o,
  input logic                  age_err_o
);
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lim_q <= '0;
    else if (reg_we_i) lim_q <= reg_lim_i;
  end

  a_r3_err_victim0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_err_o |-> itlb_victim_o == '0);

  a_r6_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && !utlb_acc_i) |=> $stable(utlb_cnt_o));

  a_r8_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && utlb_acc_i && lim_q == '0 && utlb_cnt_o != '1)
    |=> utlb_cnt_o == CNT_W'($past(utlb_cnt_o) + 1'b1));

  a_r7_wrap_lim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && utlb_acc_i && lim_q != '0 && utlb_cnt_o >= lim_q)
    |=> utlb_cnt_o == '0);

  a_r9_load_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> utlb_cnt_o == $past(reg_cnt_i));

  a_r4_hit_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && itlb_hit_i && !itlb_refill_i)
    |=> (age_err_o || itlb_victim_o != $past(itlb_hit_idx_i)));

  a_r5_refill_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && itlb_refill_i)
    |=> (age_err_o || itlb_victim_o != $past(itlb_victim_o)));
endmodule

bind tlb_repl_ptr tlb_repl_ptr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_we_i       (reg_we_i),
  .reg_lim_i      (reg_lim_i),
  .reg_cnt_i      (reg_cnt_i),
  .itlb_hit_i     (itlb_hit_i),
  .itlb_hit_idx_i (itlb_hit_idx_i),
  .itlb_refill_i  (itlb_refill_i),
  .utlb_acc_i     (utlb_acc_i),
  .itlb_victim_o  (itlb_victim_o),
  .utlb_cnt_o     (utlb_cnt_o),
  .age_err_o      (age_err_o)
);

// File: tb/tlb_repl_ptr_tb.sv
module tlb_repl_ptr_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [5:0] reg_age_i = '0, reg_lim_i = '0, reg_cnt_i = '0;
  logic       itlb_hit_i = 1'b0;
  logic [1:0] itlb_hit_idx_i = '0;
  logic       itlb_refill_i = 1'b0;
  logic       utlb_acc_i = 1'b0;
  logic [1:0] itlb_victim_o;
  logic [5:0] utlb_cnt_o;
  logic       age_err_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0] q_v[$];
  logic [5:0] q_c[$];
  logic       q_e[$];
  string      q_tag[$];

  int order[4] = '{0, 1, 2, 3};   // newest first
  int m_cnt = 0, m_lim = 0;

  always #5 clk_i = ~clk_i;

  tlb_repl_ptr u_dut (.*);

  task automatic to_front(input int s);
    int p = 0;
    for (int i = 0; i < 4; i++) if (order[i] == s) p = i;
    for (int i = p; i > 0; i--) order[i] = order[i-1];
    order[0] = s;
  endtask

  task automatic step(input logic we, input logic [5:0] age, input logic [5:0] lim,
                      input logic [5:0] cnt, input logic hit, input logic [1:0] hidx,
                      input logic rf, input logic acc, input string tag,
                      input int ov_v, input logic ov_e);
    int n;
    @(negedge clk_i);
    reg_we_i = we; reg_age_i = age; reg_lim_i = lim; reg_cnt_i = cnt;
    itlb_hit_i = hit; itlb_hit_idx_i = hidx; itlb_refill_i = rf; utlb_acc_i = acc;
    if (we) begin
      m_cnt = int'(cnt); m_lim = int'(lim);
      if (age == 6'b0) order = '{0, 1, 2, 3};
    end else begin
      if (rf)       to_front(order[3]);
      else if (hit) to_front(int'(hidx));
      if (acc) begin
        n = m_cnt + 1;
        if ((m_lim != 0 && n > m_lim) || n > 63) n = 0;
        m_cnt = n;
      end
    end
    q_v.push_back(ov_v >= 0 ? 2'(ov_v) : 2'(order[3]));
    q_e.push_back(ov_v >= 0 ? ov_e : 1'b0);
    q_c.push_back(6'(m_cnt));
    q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag, -1, 0);
  endtask
  task automatic hit(input logic [1:0] k, input string tag);
    step(0, 0, 0, 0, 1, k, 0, 0, tag, -1, 0);
  endtask
  task automatic acc(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, tag, -1, 0);
  endtask
  task automatic wr(input logic [5:0] age, input logic [5:0] lim, input logic [5:0] cnt,
                    input string tag, input int ov_v, input logic ov_e);
    step(1, age, lim, cnt, 0, 0, 0, 0, tag, ov_v, ov_e);
  endtask

  // monitor: compare each expected item after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk_i); #2;
      if (q_v.size() > 0) begin
        logic [1:0] ev; logic [5:0] ec; logic ee; string t;
        ev = q_v.pop_front(); ec = q_c.pop_front(); ee = q_e.pop_front(); t = q_tag.pop_front();
        checks++;
        if (itlb_victim_o !== ev || utlb_cnt_o !== ec || age_err_o !== ee) begin
          fails++;
          $display("FAIL %s: victim/cnt/err actual %0d/%0d/%0b expected %0d/%0d/%0b",
                   t, itlb_victim_o, utlb_cnt_o, age_err_o, ev, ec, ee);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (itlb_victim_o !== 2'd3 || utlb_cnt_o !== 6'd0 || age_err_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %0d/%0d/%0b expected 3/0/0",
               itlb_victim_o, utlb_cnt_o, age_err_o);
    end
    rst_ni = 1'b1;
    idle("R1 idle after reset");
    // R4: recency ordering from hits
    hit(1, "R4 hit 1"); hit(3, "R4 hit 3"); hit(2, "R4 hit 2"); hit(0, "R4 hit 0");
    hit(0, "R4 repeat hit 0");
    // R5: refill marks victim newest, beats a hit
    step(0, 0, 0, 0, 0, 0, 1, 0, "R5 refill", -1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, "R5 refill again", -1, 0);
    step(0, 0, 0, 0, 1, 0, 1, 0, "R5 refill over hit", -1, 0);
    // R6: increment and hold
    acc("R6 acc"); acc("R6 acc"); idle("R6 hold"); acc("R6 acc");
    // R9 + R7: limit 5
    wr(6'b0, 6'd5, 6'd3, "R9 write lim5 cnt3", -1, 0);
    acc("R7 to 4"); acc("R7 to 5"); acc("R7 wrap 0"); acc("R7 to 1");
    wr(6'b0, 6'd5, 6'd10, "R9 write cnt above lim", -1, 0);
    acc("R7 over-limit wrap");
    // R8: zero limit, full run
    wr(6'b0, 6'd0, 6'd62, "R9 write cnt62", -1, 0);
    acc("R8 to 63"); acc("R8 wrap 0");
    for (int i = 0; i < 64; i++) acc("R8 full run");
    // R9: write overrides strobes
    step(1, 6'b111000, 6'd0, 6'd7, 1, 2'd0, 1, 1, "R9 write priority", 0, 0);
    // R2 decode patterns, R3 illegal
    wr(6'b000110, 6'd0, 6'd0, "R2 slot1 pattern", 1, 0);
    wr(6'b000001, 6'd0, 6'd0, "R2 slot2 pattern", 2, 0);
    wr(6'b111111, 6'd0, 6'd0, "R2 slot0 priority", 0, 0);
    wr(6'b011011, 6'd0, 6'd0, "R3 illegal pattern", 0, 1);
    wr(6'b000000, 6'd0, 6'd0, "R2 slot3 pattern", -1, 0);
    hit(3, "R4 after reload"); idle("R4 settle");
    @(negedge clk_i); @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule